// File: doc/BRIEF.md
# Byte Arithmetic Unit with Condition Flags

This block performs one 8-bit arithmetic or bitwise operation per cycle on two operands and keeps five condition flags in a status register. The arithmetic class covers plain add, add with stored carry, subtract, subtract with stored no-borrow, increment and decrement. The bitwise class covers AND, OR and XOR. The result is combinational from the operands, the operation code and the stored carry. The status register takes the new flags at the next rising clock edge, but only when the write-back enable is high.

A subtraction is formed as the first operand plus the inverted second operand plus one. The carry flag therefore reads as "no borrow": it is set when the first operand is greater than or equal to the second. The digit-carry flag follows the same convention on the low nibble. Arithmetic operations rewrite all five flags. Bitwise operations rewrite only zero and negative. Codes outside the defined set pass the first operand through and never touch the flags.

Top module: `alu_status_unit`

## Requirements
- R1: Code 0 (add) gives (A+B) mod 256, and code 4 (increment) gives (A+1) mod 256. The carry flag (status bit 0) is set when the unbounded sum exceeds 255.
- R2: Code 1 (add with carry) gives (A+B+C) mod 256, where C is status bit 0 as held before the operation. The carry flag is set when A+B+C exceeds 255.
- R3: Code 2 (subtract) gives (A-B) mod 256, and code 5 (decrement) gives (A-1) mod 256. Status bit 0 is set exactly when A >= B (for decrement, when A >= 1).
- R4: Code 3 (subtract with borrow) gives (A-B-(1-C)) mod 256, using the held C. Status bit 0 is set exactly when A >= B+(1-C).
- R5: Status bit 2 (zero) is set after a flag-updating operation exactly when the 8-bit result is 0x00.
- R6: Status bit 4 (negative) equals bit 7 of the result after a flag-updating operation.
- R7: Status bit 1 (digit carry) shows the carry out of bit 3 of the adder. For an add it is set when the sum of the low nibbles plus carry-in exceeds 15. For a subtract it is set when the low nibble of A is at least the low nibble of B plus the borrow-in.
- R8: Status bit 3 (overflow) is set after an arithmetic operation exactly when the two's-complement result falls outside -128..127. Example: 0x70+0x20 gives 0x90 with the overflow flag set.
- R9: Codes 6, 7 and 8 give A AND B, A OR B and A XOR B. They update only status bits 2 and 4 and leave bits 0, 1 and 3 unchanged.
- R10: While the write-back enable is low, the status register keeps its value. The result output still follows the inputs.
- R11: Codes 9 to 15 output A unchanged and leave the status register unchanged.
- R12: Reset clears the status register to 0x00. Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| op_code | input | 4 | Operation select (codes 0 to 8 defined) |
| opnd_a | input | 8 | First operand (minuend for subtracts) |
| opnd_b | input | 8 | Second operand (subtrahend for subtracts) |
| wr_en | input | 1 | Commits the new flags at the next rising edge |
| result | output | 8 | Combinational operation result |
| status | output | 8 | Flag register: bit0 carry, bit1 digit carry, bit2 zero, bit3 overflow, bit4 negative |

## Verification
The hardest cases to reach are the operations whose outcome depends on flags held from before. These are add and subtract with carry, which read the stored carry, and the bitwise codes, which must keep carry, digit carry and overflow as they were. Before each swept operation, the stimulus issues a priming add from a rotating set of four operand pairs: 0xFF+0x01, 0x00+0x00, 0x80+0x80 and 0x70+0x20. This leaves the register in a known state with carry, digit carry, overflow and negative set or clear in different combinations. The operation under test then runs against every first operand and sixteen second operands spread across the full range, and a bench-side arithmetic model predicts the expected result and status.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  parameter int DATA_W = 8;
  parameter int NIB_W  = 4;
  parameter int STAT_W = 8;

  // Flag positions are fixed: consumers decode them by bit.
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;
  localparam int FLG_CNT = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8
  } alu_op_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_held,
  output logic [W-1:0] add_x,
  output logic [W-1:0] add_y,
  output logic         add_cin,
  output logic         is_arith,
  output logic         is_logic
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    add_x    = opnd_a;
    add_y    = opnd_b;
    add_cin  = 1'b0;
    is_arith = 1'b1;
    is_logic = 1'b0;
    case (alu_op_e'(op_code))
      OP_ADD:  begin add_y = opnd_b;  add_cin = 1'b0;       end
      OP_ADDC: begin add_y = opnd_b;  add_cin = carry_held; end
      OP_SUB:  begin add_y = ~opnd_b; add_cin = 1'b1;       end
      OP_SUBB: begin add_y = ~opnd_b; add_cin = carry_held; end
      OP_INC:  begin add_y = ONE;     add_cin = 1'b0;       end
      OP_DEC:  begin add_y = ~ONE;    add_cin = 1'b1;       end
      OP_AND, OP_OR, OP_XOR: begin
        is_arith = 1'b0;
        is_logic = 1'b1;
      end
      default: begin
        is_arith = 1'b0;
        is_logic = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import alu_flag_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NIB = NIB_W
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  input  logic         add_cin,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         half_carry,
  output logic         overflow
);
  logic [W:0]   full_sum;
  logic [NIB:0] low_sum;

  always_comb begin
    full_sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
    low_sum    = {1'b0, add_x[NIB-1:0]} + {1'b0, add_y[NIB-1:0]} + {{NIB{1'b0}}, add_cin};
    sum        = full_sum[W-1:0];
    carry_out  = full_sum[W];
    half_carry = low_sum[NIB];
    overflow   = (add_x[W-1] == add_y[W-1]) && (full_sum[W-1] != add_x[W-1]);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] logic_res
);
  logic sel_and;
  logic sel_or;

  always_comb begin
    sel_and = (op_code == OP_AND);
    sel_or  = (op_code == OP_OR);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign logic_res[i] = sel_and ? (opnd_a[i] & opnd_b[i]) :
                          sel_or  ? (opnd_a[i] | opnd_b[i]) :
                                    (opnd_a[i] ^ opnd_b[i]);
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upd_arith,
  input  logic              upd_logic,
  input  logic              c_new,
  input  logic              dc_new,
  input  logic              ov_new,
  input  logic              z_new,
  input  logic              n_new,
  input  logic [W-1:0]      result,
  output logic [STAT_W-1:0] status
);
  logic               rst_meta;
  logic               rst_sync_n;
  logic [FLG_CNT-1:0] flags_q;
  logic [FLG_CNT-1:0] flags_d;
  logic               flags_en;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    flags_en = wr_en && (upd_arith || upd_logic);
    flags_d  = flags_q;
    if (upd_arith) begin
      flags_d[FLG_C]  = c_new;
      flags_d[FLG_DC] = dc_new;
      flags_d[FLG_OV] = ov_new;
      flags_d[FLG_Z]  = z_new;
      flags_d[FLG_N]  = n_new;
    end else if (upd_logic) begin
      flags_d[FLG_Z]  = z_new;
      flags_d[FLG_N]  = n_new;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign status = {{(STAT_W-FLG_CNT){1'b0}}, flags_q};

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(status)); // R10

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !upd_arith && !upd_logic) |=> $stable(status)); // R11

  AST_LOGIC_KEEPS_ARITH_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && upd_logic) |=> ($stable(status[FLG_C]) && $stable(status[FLG_DC]) && $stable(status[FLG_OV]))); // R9

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (upd_arith || upd_logic)) |=> (status[FLG_Z] == ($past(result) == '0))); // R5

  AST_NEG_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (upd_arith || upd_logic)) |=> (status[FLG_N] == $past(result[W-1]))); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status[STAT_W-1:FLG_CNT] == '0); // R12
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              wr_en,
  output logic [DATA_W-1:0] result,
  output logic [STAT_W-1:0] status
);
  logic [DATA_W-1:0] add_x;
  logic [DATA_W-1:0] add_y;
  logic              add_cin;
  logic              is_arith;
  logic              is_logic;
  logic [DATA_W-1:0] sum;
  logic              carry_out;
  logic              half_carry;
  logic              overflow;
  logic [DATA_W-1:0] logic_res;
  logic              z_new;
  logic              n_new;

  alu_operand_sel #(.W(DATA_W)) u_sel (
    .op_code    (op_code),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .carry_held (status[FLG_C]),
    .add_x      (add_x),
    .add_y      (add_y),
    .add_cin    (add_cin),
    .is_arith   (is_arith),
    .is_logic   (is_logic)
  );

  alu_adder #(.W(DATA_W), .NIB(NIB_W)) u_add (
    .add_x      (add_x),
    .add_y      (add_y),
    .add_cin    (add_cin),
    .sum        (sum),
    .carry_out  (carry_out),
    .half_carry (half_carry),
    .overflow   (overflow)
  );

  alu_logic_unit #(.W(DATA_W)) u_logic (
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .logic_res (logic_res)
  );

  always_comb begin
    if (is_arith)      result = sum;
    else if (is_logic) result = logic_res;
    else               result = opnd_a;
    z_new = (result == '0);
    n_new = result[DATA_W-1];
  end

  alu_status_reg #(.W(DATA_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .upd_arith (is_arith),
    .upd_logic (is_logic),
    .c_new     (carry_out),
    .dc_new    (half_carry),
    .ov_new    (overflow),
    .z_new     (z_new),
    .n_new     (n_new),
    .result    (result),
    .status    (status)
  );
endmodule

// File: tb/alu_status_unit_tb.sv
`timescale 1ns/1ps
module alu_status_unit_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] op_code;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic       wr_en;
  logic [7:0] result;
  logic [7:0] status;

  int n_checks;
  int n_fails;
  logic [7:0] exp_st;

  alu_status_unit u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .wr_en   (wr_en),
    .result  (result),
    .status  (status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference: returns {status_after, result}, given the status held before.
  function automatic logic [15:0] ref_op(int op, int a, int b, logic [7:0] st);
    int cin, bw, sa, sb, r;
    logic c, dc, ov;
    logic [7:0] res, ns;
    int kind; // 0 arith, 1 logic, 2 none
    cin = int'(st[0]);
    bw  = 1 - cin;
    sa  = (a > 127) ? a - 256 : a;
    sb  = (b > 127) ? b - 256 : b;
    c = 1'b0; dc = 1'b0; ov = 1'b0; kind = 0; r = a;
    case (op)
      0: begin r = a + b; c = (r > 255); dc = ((a & 15) + (b & 15)) > 15;
               ov = (sa + sb > 127) || (sa + sb < -128); end
      1: begin r = a + b + cin; c = (r > 255); dc = ((a & 15) + (b & 15) + cin) > 15;
               ov = (sa + sb + cin > 127) || (sa + sb + cin < -128); end
      2: begin r = a - b; c = (a >= b); dc = (a & 15) >= (b & 15);
               ov = (sa - sb > 127) || (sa - sb < -128); end
      3: begin r = a - b - bw; c = (a >= b + bw); dc = (a & 15) >= ((b & 15) + bw);
               ov = (sa - sb - bw > 127) || (sa - sb - bw < -128); end
      4: begin r = a + 1; c = (a == 255); dc = (a & 15) == 15; ov = (a == 127); end
      5: begin r = a - 1; c = (a >= 1); dc = (a & 15) >= 1; ov = (a == 128); end
      6: begin r = a & b; kind = 1; end
      7: begin r = a | b; kind = 1; end
      8: begin r = a ^ b; kind = 1; end
      default: begin r = a; kind = 2; end
    endcase
    res = r[7:0];
    ns  = st;
    if (kind == 0) ns = {3'b000, res[7], ov, (res == 8'h00), dc, c};
    else if (kind == 1) begin ns[2] = (res == 8'h00); ns[4] = res[7]; end
    return {ns, res};
  endfunction

  function automatic string tag_of(int op, logic we, logic [7:0] diff);
    if (!we) return "R10";
    if (op > 8) return "R11";
    if (op >= 6) return "R9";
    if (diff[7:5] != 3'b000) return "R12";
    if (diff[2]) return "R5";
    if (diff[4]) return "R6";
    if (diff[1]) return "R7";
    if (diff[3]) return "R8";
    case (op)
      0, 4: return "R1";
      1: return "R2";
      2, 5: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(int op, int a, int b, logic we);
    logic [15:0] pr;
    logic [7:0] diff;
    @(negedge clk);
    op_code = op[3:0];
    opnd_a  = a[7:0];
    opnd_b  = b[7:0];
    wr_en   = we;
    #1;
    pr = ref_op(op, a, b, exp_st);
    n_checks++;
    if (result !== pr[7:0]) begin
      n_fails++;
      $display("FAIL %s result op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               tag_of(op, 1'b1, 8'h00), op, a, b, result, pr[7:0]);
    end
    @(posedge clk);
    #1;
    if (we) exp_st = pr[15:8];
    diff = status ^ exp_st;
    n_checks++;
    if (diff != 8'h00) begin
      n_fails++;
      $display("FAIL %s status op=%0d a=%02h b=%02h we=%0b actual=%02h expected=%02h",
               tag_of(op, we, diff), op, a, b, we, status, exp_st);
    end
  endtask

  initial begin
    #(190000 * 5.0);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    exp_st   = 8'h00;
    rst_n    = 1'b0;
    op_code  = 4'd0;
    opnd_a   = 8'h00;
    opnd_b   = 8'h00;
    wr_en    = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_checks++; // R12 reset value
    if (status !== 8'h00) begin
      n_fails++;
      $display("FAIL R12 reset status actual=%02h expected=00", status);
    end

    // Worked cases from R8 and R1.
    apply(0, 8'h70, 8'h20, 1'b1); // R8: 0x90 with overflow
    apply(0, 8'hFF, 8'h01, 1'b1); // R1: 0x00 with carry and zero

    // Sweep defined codes, each preceded by a priming add that sets up flags.
    for (int op = 0; op <= 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          int sel;
          sel = (a ^ bi) & 3;
          case (sel)
            0: apply(0, 8'hFF, 8'h01, 1'b1);
            1: apply(0, 8'h00, 8'h00, 1'b1);
            2: apply(0, 8'h80, 8'h80, 1'b1);
            default: apply(0, 8'h70, 8'h20, 1'b1);
          endcase
          apply(op, a, bi * 17, 1'b1); // R1..R9 by code
        end
      end
    end

    // R10: enable low keeps flags, result still live.
    for (int i = 0; i < 256; i++) begin
      if ((i & 15) == 0) apply(0, 8'h80, 8'h80, 1'b1);
      apply(i % 9, i, 255 - i, 1'b0);
    end

    // R11: undefined codes pass A and keep flags.
    for (int op = 9; op < 16; op++) begin
      apply(0, 8'hFF, 8'h01, 1'b1);
      for (int a = 0; a < 256; a += 4) apply(op, a, 255 - a, 1'b1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule